// File: doc/BRIEF.md
# Interrupt and Exception Entry Sequencer

This block takes over the core for a few cycles whenever control must move into or out of a service routine on a 16-bit processor. The processor has a status word, two stack pointers (supervisor and user) and a 256-entry table of routine start addresses. Three events start the entry sequence. The first is a device interrupt accepted at an instruction boundary. The second is an undefined-opcode detect. The third is a return-from-service instruction issued in user mode.

On entry the sequencer moves to the supervisor stack and stores the interrupted status word and PC on it. It then switches the status word to supervisor mode and fetches the new PC from the table slot chosen by the event. A return-from-service issued in supervisor mode runs the reverse sequence. It pops the PC and the status word, then puts in R6 the stack pointer that matches the restored privilege.

The core shows the sequencer its current status word, its PC and its R6. The sequencer writes them back through write strobes. It drives a memory port whose read data is valid in the same cycle as the address. While `busy_o` is high, the core must not fetch and must not change these registers.

Top module: `intx_sequencer`

## Requirements
- R1: `busy_o` rises the cycle after an accepted event. It stays high for exactly 3 cycles for an entry and exactly 2 cycles for a return. Events presented while `busy_o` is high are ignored. While idle, no write strobe and no memory enable is driven.
- R2: If an exception and an acceptable interrupt are presented in the same cycle, the exception is serviced and the interrupt is not.
- R3: An interrupt is accepted only when `insn_done_i` is high and its level is strictly greater than status bits [10:8]. Otherwise nothing changes: no busy, and PC, status and R6 stay as they were.
- R4: The vector is x01 for an undefined opcode and x00 for a user-mode return. For an interrupt it is x80 OR'd with the 7-bit device code. The new PC is the memory word at address x0100 plus the vector, so exceptions use x0100 to x017F and interrupts use x0180 to x01FF.
- R5: On entry with stack base S, the old status word is written to S-1 and then the old PC is written to S-2 on the next cycle. R6 ends at S-2.
- R6: When status bit 15 is 1 (user), S is the stored supervisor pointer and the old R6 is kept as the user pointer. When bit 15 is 0, S is the current R6.
- R7: The status word after entry has bit 15 cleared. For an interrupt, bits [10:8] take the device level. For an exception, bits [10:8] are unchanged. All other bits are kept.
- R8: A return in supervisor mode loads the PC from the word at R6 and then the status word from the word at R6+1.
- R9: After a return, if the restored bit 15 is 1, R6 is loaded with the stored user pointer and R6+2 becomes the stored supervisor pointer. Otherwise R6 becomes R6+2.
- R10: After reset the block is idle with no strobes, and the stored supervisor pointer equals the parameter `SSP_INIT`.
- R11: An undefined-opcode event is accepted in any idle cycle, whether or not `insn_done_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ill_op_i | input | 1 | Undefined opcode detected |
| rti_i | input | 1 | Return-from-service instruction issued |
| insn_done_i | input | 1 | Current instruction completes this cycle |
| irq_req_i | input | 1 | Device interrupt request |
| irq_lvl_i | input | 3 | Device priority level |
| irq_vec_i | input | 7 | Device code (the low 7 bits of its vector) |
| cur_psr_i | input | 16 | Current status word |
| cur_pc_i | input | 16 | PC to resume at |
| r6_rdata_i | input | 16 | Current R6 |
| mem_rdata_i | input | 16 | Memory read data, valid in the same cycle |
| busy_o | output | 1 | Sequence in progress, core fetch stalled |
| mem_en_o | output | 1 | Memory access strobe |
| mem_we_o | output | 1 | Memory write (when `mem_en_o` is high) |
| mem_addr_o | output | 16 | Memory address |
| mem_wdata_o | output | 16 | Memory write data |
| pc_we_o | output | 1 | PC write strobe |
| pc_wdata_o | output | 16 | New PC |
| psr_we_o | output | 1 | Status word write strobe |
| psr_wdata_o | output | 16 | New status word |
| r6_we_o | output | 1 | R6 write strobe |
| r6_wdata_o | output | 16 | New R6 |

## Verification
A wrong stored stack pointer does not show up until the next privilege change. It then appears as a push to the wrong address, or as the wrong R6 after a return, so the stimulus alternates user-mode and supervisor-mode entries and returns, and a pointer error shows up one event later. A wrong latched cause shows up as a PC taken from the wrong table half in the third busy cycle. A wrong state sequence shows up at once as a busy length other than 3 or 2.

// File: rtl/intx_pkg.sv
package intx_pkg;
  localparam int unsigned PSR_PRIV_BIT = 15;
  localparam int unsigned PSR_PRIO_LO  = 8;
  localparam logic [7:0]  VEC_PRIV_FAULT = 8'h00;
  localparam logic [7:0]  VEC_BAD_OPCODE = 8'h01;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_SR,
    ST_PUSH_PC,
    ST_LOAD_VEC,
    ST_POP_PC,
    ST_POP_SR
  } seq_state_t;
endpackage

// File: rtl/intx_arbiter.sv
module intx_arbiter #(
  parameter int unsigned VEC_W  = 8,
  parameter int unsigned PRIO_W = 3
) (
  input  logic              ready_i,
  input  logic              ill_op_i,
  input  logic              rti_i,
  input  logic              user_mode_i,
  input  logic              insn_done_i,
  input  logic              irq_req_i,
  input  logic [PRIO_W-1:0] irq_lvl_i,
  input  logic [VEC_W-2:0]  irq_vec_i,
  input  logic [PRIO_W-1:0] cur_prio_i,
  output logic              take_o,
  output logic              is_entry_o,
  output logic              is_irq_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic [PRIO_W-1:0] prio_o
);
  import intx_pkg::*;

  logic priv_fault;
  logic exc_hit;
  logic irq_ok;
  logic legal_ret;
  logic irq_win;

  always_comb begin
    priv_fault = rti_i & user_mode_i;
    exc_hit    = ill_op_i | priv_fault;
    irq_ok     = irq_req_i & insn_done_i & (irq_lvl_i > cur_prio_i);
    legal_ret  = rti_i & ~user_mode_i & ~ill_op_i;
    irq_win    = irq_ok & ~exc_hit & ~rti_i;

    take_o     = ready_i & (exc_hit | legal_ret | irq_win);
    is_entry_o = exc_hit | irq_win;
    is_irq_o   = irq_win;

    if (ill_op_i)        vec_o = VEC_W'(VEC_BAD_OPCODE);
    else if (priv_fault) vec_o = VEC_W'(VEC_PRIV_FAULT);
    else                 vec_o = {1'b1, irq_vec_i};

    prio_o = irq_win ? irq_lvl_i : cur_prio_i;
  end
endmodule

// File: rtl/intx_sp_bank.sv
module intx_sp_bank #(
  parameter int unsigned W        = 16,
  parameter logic [W-1:0] SSP_INIT = 16'h3000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ssp_we_i,
  input  logic [W-1:0] ssp_d_i,
  input  logic         usp_we_i,
  input  logic [W-1:0] usp_d_i,
  output logic [W-1:0] ssp_q_o,
  output logic [W-1:0] usp_q_o
);
  logic [W-1:0] ssp_q, ssp_d;
  logic [W-1:0] usp_q, usp_d;

  always_comb begin
    ssp_d = ssp_we_i ? ssp_d_i : ssp_q;
    usp_d = usp_we_i ? usp_d_i : usp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ssp_q <= SSP_INIT;
      usp_q <= '0;
    end else begin
      ssp_q <= ssp_d;
      usp_q <= usp_d;
    end
  end

  assign ssp_q_o = ssp_q;
  assign usp_q_o = usp_q;

  AST_ONE_POINTER_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(ssp_we_i && usp_we_i)); // R6
endmodule

// File: rtl/intx_fsm.sv
module intx_fsm #(
  parameter int unsigned  W        = 16,
  parameter int unsigned  VEC_W    = 8,
  parameter int unsigned  PRIO_W   = 3,
  parameter logic [W-1:0] TBL_BASE = 16'h0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic              is_entry_i,
  input  logic              is_irq_i,
  input  logic [VEC_W-1:0]  vec_i,
  input  logic [PRIO_W-1:0] prio_i,
  input  logic [W-1:0]      cur_psr_i,
  input  logic [W-1:0]      cur_pc_i,
  input  logic [W-1:0]      r6_rdata_i,
  input  logic [W-1:0]      mem_rdata_i,
  input  logic [W-1:0]      ssp_q_i,
  input  logic [W-1:0]      usp_q_i,
  output logic              busy_o,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [W-1:0]      mem_addr_o,
  output logic [W-1:0]      mem_wdata_o,
  output logic              pc_we_o,
  output logic [W-1:0]      pc_wdata_o,
  output logic              psr_we_o,
  output logic [W-1:0]      psr_wdata_o,
  output logic              r6_we_o,
  output logic [W-1:0]      r6_wdata_o,
  output logic              ssp_we_o,
  output logic [W-1:0]      ssp_d_o,
  output logic              usp_we_o,
  output logic [W-1:0]      usp_d_o
);
  import intx_pkg::*;

  localparam logic [W-1:0] IRQ_BASE = TBL_BASE + W'(1 << (VEC_W - 1));
  localparam logic [W-1:0] ONE      = W'(1);

  seq_state_t        state_q, state_d;
  logic [W-1:0]      sv_psr_q, sv_pc_q;
  logic [VEC_W-1:0]  vec_q;
  logic [PRIO_W-1:0] prio_q;
  logic              irq_q;
  logic [W-1:0]      sp_q, sp_d;
  logic              sp_en;
  logic              cap_en;
  logic [W-1:0]      base;
  logic [W-1:0]      psr_entry;

  // Next-state and output decode
  always_comb begin
    state_d     = state_q;
    sp_en       = 1'b0;
    sp_d        = sp_q;
    mem_en_o    = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    pc_we_o     = 1'b0;
    pc_wdata_o  = mem_rdata_i;
    psr_we_o    = 1'b0;
    psr_wdata_o = '0;
    r6_we_o     = 1'b0;
    r6_wdata_o  = '0;
    ssp_we_o    = 1'b0;
    ssp_d_o     = '0;
    usp_we_o    = 1'b0;
    usp_d_o     = r6_rdata_i;
    cap_en      = 1'b0;

    base = sv_psr_q[PSR_PRIV_BIT] ? ssp_q_i : r6_rdata_i;
    psr_entry = sv_psr_q;
    psr_entry[PSR_PRIV_BIT] = 1'b0;
    psr_entry[PSR_PRIO_LO +: PRIO_W] = prio_q;

    unique case (state_q)
      ST_IDLE: begin
        if (take_i) begin
          cap_en  = 1'b1;
          state_d = is_entry_i ? ST_PUSH_SR : ST_POP_PC;
        end
      end
      ST_PUSH_SR: begin
        mem_en_o    = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = base - ONE;
        mem_wdata_o = sv_psr_q;
        usp_we_o    = sv_psr_q[PSR_PRIV_BIT];
        sp_en       = 1'b1;
        sp_d        = base - ONE;
        state_d     = ST_PUSH_PC;
      end
      ST_PUSH_PC: begin
        mem_en_o    = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = sp_q - ONE;
        mem_wdata_o = sv_pc_q;
        r6_we_o     = 1'b1;
        r6_wdata_o  = sp_q - ONE;
        psr_we_o    = 1'b1;
        psr_wdata_o = psr_entry;
        state_d     = ST_LOAD_VEC;
      end
      ST_LOAD_VEC: begin
        mem_en_o   = 1'b1;
        mem_addr_o = TBL_BASE + W'(vec_q);
        pc_we_o    = 1'b1;
        state_d    = ST_IDLE;
      end
      ST_POP_PC: begin
        mem_en_o   = 1'b1;
        mem_addr_o = r6_rdata_i;
        pc_we_o    = 1'b1;
        sp_en      = 1'b1;
        sp_d       = r6_rdata_i + ONE;
        state_d    = ST_POP_SR;
      end
      ST_POP_SR: begin
        mem_en_o    = 1'b1;
        mem_addr_o  = sp_q;
        psr_we_o    = 1'b1;
        psr_wdata_o = mem_rdata_i;
        r6_we_o     = 1'b1;
        if (mem_rdata_i[PSR_PRIV_BIT]) begin
          r6_wdata_o = usp_q_i;
          ssp_we_o   = 1'b1;
          ssp_d_o    = sp_q + ONE;
        end else begin
          r6_wdata_o = sp_q + ONE;
        end
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      sv_psr_q <= '0;
      sv_pc_q  <= '0;
      vec_q    <= '0;
      prio_q   <= '0;
      irq_q    <= 1'b0;
      sp_q     <= '0;
    end else begin
      state_q <= state_d;
      if (cap_en) begin
        sv_psr_q <= cur_psr_i;
        sv_pc_q  <= cur_pc_i;
        vec_q    <= vec_i;
        prio_q   <= prio_i;
        irq_q    <= is_irq_i;
      end
      if (sp_en) sp_q <= sp_d;
    end
  end

  assign busy_o = (state_q != ST_IDLE);

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !(mem_en_o || pc_we_o || psr_we_o || r6_we_o)); // R1
  AST_WRITE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> mem_en_o); // R5
  AST_PUSH_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_o) |=> mem_we_o ##1 (pc_we_o && !mem_we_o)); // R1
  AST_PUSH_ADJACENT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o && r6_we_o) |-> (mem_addr_o == $past(mem_addr_o) - ONE)); // R5
  AST_ENTRY_SUPERVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o && psr_we_o) |-> !psr_wdata_o[PSR_PRIV_BIT]); // R7
  AST_EXC_KEEPS_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o && psr_we_o && !irq_q) |->
      (psr_wdata_o[PSR_PRIO_LO +: PRIO_W] == sv_psr_q[PSR_PRIO_LO +: PRIO_W])); // R7
  AST_TABLE_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOAD_VEC) |-> ((mem_addr_o >= IRQ_BASE) == irq_q)); // R4
endmodule

// File: rtl/intx_sequencer.sv
module intx_sequencer #(
  parameter int unsigned  W        = 16,
  parameter int unsigned  VEC_W    = 8,
  parameter int unsigned  PRIO_W   = 3,
  parameter logic [W-1:0] TBL_BASE = 16'h0100,
  parameter logic [W-1:0] SSP_INIT = 16'h3000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ill_op_i,
  input  logic              rti_i,
  input  logic              insn_done_i,
  input  logic              irq_req_i,
  input  logic [PRIO_W-1:0] irq_lvl_i,
  input  logic [VEC_W-2:0]  irq_vec_i,
  input  logic [W-1:0]      cur_psr_i,
  input  logic [W-1:0]      cur_pc_i,
  input  logic [W-1:0]      r6_rdata_i,
  input  logic [W-1:0]      mem_rdata_i,
  output logic              busy_o,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [W-1:0]      mem_addr_o,
  output logic [W-1:0]      mem_wdata_o,
  output logic              pc_we_o,
  output logic [W-1:0]      pc_wdata_o,
  output logic              psr_we_o,
  output logic [W-1:0]      psr_wdata_o,
  output logic              r6_we_o,
  output logic [W-1:0]      r6_wdata_o
);
  import intx_pkg::*;

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic              take, is_entry, is_irq;
  logic [VEC_W-1:0]  vec;
  logic [PRIO_W-1:0] new_prio;
  logic              ssp_we, usp_we;
  logic [W-1:0]      ssp_d, usp_d, ssp_q, usp_q;

  intx_arbiter #(.VEC_W(VEC_W), .PRIO_W(PRIO_W)) u_arb (
    .ready_i     (!busy_o),
    .ill_op_i    (ill_op_i),
    .rti_i       (rti_i),
    .user_mode_i (cur_psr_i[PSR_PRIV_BIT]),
    .insn_done_i (insn_done_i),
    .irq_req_i   (irq_req_i),
    .irq_lvl_i   (irq_lvl_i),
    .irq_vec_i   (irq_vec_i),
    .cur_prio_i  (cur_psr_i[PSR_PRIO_LO +: PRIO_W]),
    .take_o      (take),
    .is_entry_o  (is_entry),
    .is_irq_o    (is_irq),
    .vec_o       (vec),
    .prio_o      (new_prio)
  );

  intx_sp_bank #(.W(W), .SSP_INIT(SSP_INIT)) u_bank (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .ssp_we_i (ssp_we),
    .ssp_d_i  (ssp_d),
    .usp_we_i (usp_we),
    .usp_d_i  (usp_d),
    .ssp_q_o  (ssp_q),
    .usp_q_o  (usp_q)
  );

  intx_fsm #(.W(W), .VEC_W(VEC_W), .PRIO_W(PRIO_W), .TBL_BASE(TBL_BASE)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .take_i      (take),
    .is_entry_i  (is_entry),
    .is_irq_i    (is_irq),
    .vec_i       (vec),
    .prio_i      (new_prio),
    .cur_psr_i   (cur_psr_i),
    .cur_pc_i    (cur_pc_i),
    .r6_rdata_i  (r6_rdata_i),
    .mem_rdata_i (mem_rdata_i),
    .ssp_q_i     (ssp_q),
    .usp_q_i     (usp_q),
    .busy_o      (busy_o),
    .mem_en_o    (mem_en_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .pc_we_o     (pc_we_o),
    .pc_wdata_o  (pc_wdata_o),
    .psr_we_o    (psr_we_o),
    .psr_wdata_o (psr_wdata_o),
    .r6_we_o     (r6_we_o),
    .r6_wdata_o  (r6_wdata_o),
    .ssp_we_o    (ssp_we),
    .ssp_d_o     (ssp_d),
    .usp_we_o    (usp_we),
    .usp_d_o     (usp_d)
  );

  AST_EXC_OVER_IRQ: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (take && ill_op_i) |-> (!is_irq && vec == VEC_W'(VEC_BAD_OPCODE))); // R2
  AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    take |=> busy_o); // R1
endmodule

// File: tb/test_intx_sequencer.sv
module test_intx_sequencer;
  localparam logic [15:0] SSP0 = 16'h3000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        ill_op, rti, insn_done, irq_req;
  logic [2:0]  irq_lvl;
  logic [6:0]  irq_vec;
  logic [15:0] core_psr, core_pc, core_r6;
  logic [15:0] mem_rdata;
  logic        busy, mem_en, mem_we, pc_we, psr_we, r6_we;
  logic [15:0] mem_addr, mem_wdata, pc_wdata, psr_wdata, r6_wdata;

  logic [15:0] mem [0:1023];
  assign mem_rdata = mem[mem_addr[9:0]];

  logic        bd_mem_we, bd_core;
  logic [15:0] bd_addr, bd_data, bd_psr, bd_pc, bd_r6;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] m_ssp, m_usp;
  bit done_flag = 0;

  intx_sequencer i_intx_sequencer (
    .clk(clk), .rst_n(rst_n), .ill_op_i(ill_op), .rti_i(rti),
    .insn_done_i(insn_done), .irq_req_i(irq_req), .irq_lvl_i(irq_lvl),
    .irq_vec_i(irq_vec), .cur_psr_i(core_psr), .cur_pc_i(core_pc),
    .r6_rdata_i(core_r6), .mem_rdata_i(mem_rdata), .busy_o(busy),
    .mem_en_o(mem_en), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .pc_we_o(pc_we), .pc_wdata_o(pc_wdata),
    .psr_we_o(psr_we), .psr_wdata_o(psr_wdata), .r6_we_o(r6_we),
    .r6_wdata_o(r6_wdata)
  );

  function automatic logic [15:0] tbl(input int i);
    return 16'h4000 + 16'(i * 5);
  endfunction

  function automatic logic [15:0] rd(input logic [15:0] a);
    return mem[a[9:0]];
  endfunction

  // Bench-side memory and core register model
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[256 + i] <= tbl(i);
      core_psr <= bd_psr;
      core_pc  <= bd_pc;
      core_r6  <= bd_r6;
    end else begin
      if (mem_en && mem_we) mem[mem_addr[9:0]] <= mem_wdata;
      if (bd_mem_we) mem[bd_addr[9:0]] <= bd_data;
      if (bd_core) begin
        core_psr <= bd_psr;
        core_pc  <= bd_pc;
        core_r6  <= bd_r6;
      end else begin
        if (pc_we)  core_pc  <= pc_wdata;
        if (psr_we) core_psr <= psr_wdata;
        if (r6_we)  core_r6  <= r6_wdata;
      end
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_core(input logic [15:0] psr, input logic [15:0] pc, input logic [15:0] r6);
    @(negedge clk);
    bd_psr = psr; bd_pc = pc; bd_r6 = r6; bd_core = 1'b1;
    @(negedge clk);
    bd_core = 1'b0;
  endtask

  task automatic poke(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    bd_addr = a; bd_data = d; bd_mem_we = 1'b1;
    @(negedge clk);
    bd_mem_we = 1'b0;
  endtask

  task automatic fire(input logic i_ill, input logic i_rti, input logic i_done,
                      input logic i_irq, input logic [2:0] lvl, input logic [6:0] vec,
                      input int hold, output int cyc);
    @(negedge clk);
    ill_op = i_ill; rti = i_rti; insn_done = i_done; irq_req = i_irq;
    irq_lvl = lvl; irq_vec = vec;
    cyc = 0;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      if (k >= hold) begin
        ill_op = 0; rti = 0; insn_done = 0; irq_req = 0;
      end
      if (busy) cyc++;
      else if (k >= hold) break;
    end
  endtask

  task automatic exercise(input string lbl, input logic i_ill, input logic i_rti,
                          input logic i_done, input logic i_irq, input logic [2:0] lvl,
                          input logic [6:0] vec, input int hold);
    logic [15:0] p_psr, p_pc, p_r6, base, e_psr, np, nsr;
    logic exc, irq_ok;
    logic [7:0] v;
    int cyc;
    p_psr = core_psr; p_pc = core_pc; p_r6 = core_r6;
    exc    = i_ill || (i_rti && p_psr[15]);
    irq_ok = i_irq && i_done && (lvl > p_psr[10:8]);
    np  = rd(p_r6);
    nsr = rd(p_r6 + 16'd1);
    fire(i_ill, i_rti, i_done, i_irq, lvl, vec, hold, cyc);
    if (exc || (irq_ok && !i_rti)) begin
      v = i_ill ? 8'h01 : (exc ? 8'h00 : {1'b1, vec});
      base = p_psr[15] ? m_ssp : p_r6;
      if (p_psr[15]) m_usp = p_r6;
      e_psr = p_psr;
      e_psr[15] = 1'b0;
      if (!exc) e_psr[10:8] = lvl;
      chk({lbl, " R1 entry busy length"}, 16'(cyc), 16'd3);
      chk({lbl, " R5 status pushed at S-1"}, rd(base - 16'd1), p_psr);
      chk({lbl, " R5 pc pushed at S-2"}, rd(base - 16'd2), p_pc);
      chk({lbl, " R6 stack pointer after entry"}, core_r6, base - 16'd2);
      chk({lbl, " R4 pc from table"}, core_pc, tbl(int'(v)));
      chk({lbl, " R7 status after entry"}, core_psr, e_psr);
    end else if (i_rti) begin
      chk({lbl, " R1 return busy length"}, 16'(cyc), 16'd2);
      chk({lbl, " R8 popped pc"}, core_pc, np);
      chk({lbl, " R8 popped status"}, core_psr, nsr);
      if (nsr[15]) begin
        chk({lbl, " R9 user pointer restored"}, core_r6, m_usp);
        m_ssp = p_r6 + 16'd2;
      end else begin
        chk({lbl, " R9 supervisor pointer restored"}, core_r6, p_r6 + 16'd2);
      end
    end else begin
      chk({lbl, " R3 no busy"}, 16'(cyc), 16'd0);
      chk({lbl, " R3 pc unchanged"}, core_pc, p_pc);
      chk({lbl, " R3 status unchanged"}, core_psr, p_psr);
      chk({lbl, " R3 r6 unchanged"}, core_r6, p_r6);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] psr, r6, fpsr;
    logic [2:0] pr;
    int sc;
    void'($urandom(32'd5150));
    ill_op = 0; rti = 0; insn_done = 0; irq_req = 0; irq_lvl = 0; irq_vec = 0;
    bd_mem_we = 0; bd_core = 0; bd_addr = 0; bd_data = 0;
    bd_psr = 16'h8002; bd_pc = 16'h3100; bd_r6 = 16'h8240;
    m_ssp = SSP0; m_usp = 16'h0000;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R10 busy in reset", 16'(busy), 16'd0);
    chk("R10 memory idle in reset", 16'(mem_en), 16'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 busy after reset", 16'(busy), 16'd0);
    chk("R10 strobes after reset", 16'({pc_we, psr_we, r6_we, mem_en}), 16'd0);

    // user-mode undefined opcode without instruction boundary: uses SSP_INIT (R10, R11)
    exercise("R10 R11 first user illegal", 1, 0, 0, 0, 3'd0, 7'd0, 1);
    // return to the user program (R9)
    exercise("R9 legal return to user", 0, 1, 1, 0, 3'd0, 7'd0, 1);
    // user-mode return: privilege fault vector x00
    exercise("R4 user return fault", 0, 1, 1, 0, 3'd0, 7'd0, 1);
    // exception and interrupt together (R2)
    set_core(16'h8104, 16'h3200, 16'h8250);
    exercise("R2 illegal with irq", 1, 0, 1, 1, 3'd6, 7'h15, 1);
    // interrupt at equal level, and without boundary (R3)
    set_core(16'h0401, 16'h3300, 16'h3390);
    exercise("R3 equal level", 0, 0, 1, 1, 3'd4, 7'h02, 1);
    exercise("R3 no boundary", 0, 0, 0, 1, 3'd7, 7'h02, 1);
    // accepted interrupt, held during busy (R1)
    exercise("R1 R7 irq held while busy", 0, 0, 1, 1, 3'd5, 7'h7F, 3);
    exercise("R8 return from irq", 0, 1, 1, 0, 3'd0, 7'd0, 1);

    for (int it = 0; it < 60; it++) begin
      pr = 3'($urandom % 8);
      psr = {1'($urandom % 2), 4'b0, pr, 5'b0, 3'(1 << ($urandom % 3))};
      r6 = psr[15] ? (16'h8200 + 16'($urandom % 200)) : (16'h3380 + 16'($urandom % 100));
      set_core(psr, 16'($urandom), r6);
      sc = int'($urandom % 5);
      if (sc == 1 || sc == 4) begin
        fpsr = {1'($urandom % 2), 4'b0, 3'($urandom % 8), 5'b0, 3'(1 << ($urandom % 3))};
        poke(r6, 16'($urandom));
        poke(r6 + 16'd1, fpsr);
        exercise("R8 R9 random return", 0, 1, 1, 0, 3'd0, 7'd0, 1);
      end else if (sc == 0) begin
        exercise("R11 random illegal", 1, 0, 1'($urandom % 2), 0, 3'd0, 7'd0, 1);
      end else if (sc == 2) begin
        exercise("R3 R7 random irq", 0, 0, 1'($urandom % 2), 1, 3'($urandom % 8),
                 7'($urandom), 1);
      end else begin
        exercise("R2 random both", 1, 0, 1, 1, 3'd7, 7'($urandom), 1);
      end
    end

    done_flag = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule